// File: doc/BRIEF.md
# Pseudo-SRAM Power Mode Sequencer

This block sits on the controller side of a memory built from single-transistor DRAM cells behind an SRAM-style pin interface. It owns the memory's active-low chip select and active-low sleep pins. It walks the part through power-up, normal operation, low-current standby and the deep power-down state in which the array loses its contents. Every wait interval is a parameter counted in clock cycles, so the same logic serves any controller clock.

After power is reported good, and again after each return from deep power-down, the sequencer holds chip select inactive for an initial settle interval. It then finishes wake-up in one of two ways. It can ask a separate cycle generator for two dummy reads, handshaking each one through a completion strobe. Or, when `skip_dummy` is high, it keeps chip select inactive for a longer quiet interval. Only then does it raise `ready`, and while ready the host's select request passes straight to the chip select pin. A sleep request drives the sleep pin low for at least a minimum dwell. A wake request starts the wake-up path again and raises a sticky data-lost flag, which software clears by acknowledging it.

Top module: `psram_pwr_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cs_n`=1, `zz_n`=1, `ready`=0, `rd_req`=0 and `data_lost`=0.
- R2: From the cycle after `pwr_good` is first sampled high, `cs_n`=1, `zz_n`=1, `ready`=0 and `rd_req`=0 for exactly T_INIT cycles.
- R3: With `skip_dummy`=0 at the end of a settle interval, `rd_req`=1 and `cs_n`=0 until two `rd_done` pulses have been sampled, and `ready` rises in the cycle after the second one.
- R4: With `skip_dummy`=1 at the end of a settle interval, `rd_req` stays 0 and `cs_n` stays 1 for T_QUIET further cycles, then `ready` rises.
- R5: While `ready`=1, `cs_n` equals the inverse of `host_sel` in the same cycle, `zz_n`=1 and `rd_req`=0.
- R6: A sleep request sampled while ready gives `zz_n`=0, `cs_n`=1 and `ready`=0 in the next cycle. `zz_n` then stays 0 for at least T_ZZMIN cycles, even when a wake request arrives.
- R7: A wake request in deep power-down raises `zz_n` with `cs_n`=1 in the next cycle, runs a T_INIT settle interval, then completes as in R3 or R4.
- R8: `data_lost` rises in the cycle in which `zz_n` returns high after deep power-down. It stays 1 until `lost_ack` is sampled high and clears in the following cycle.
- R9: A sleep request that arrives before `ready` is held and takes effect in the cycle after `ready` is reached. A wake request that arrives during the minimum sleep dwell is held and ends the sleep exactly T_ZZMIN cycles after it began.
- R10: A wake request outside deep power-down is dropped, so a later sleep stays in deep power-down with no new wake. A sleep request during deep power-down has no effect.
- R11: When `pwr_good` is sampled low in any state, `ready`=0, `cs_n`=1, `zz_n`=1 and `rd_req`=0 in the next cycle. The R2 sequence restarts once `pwr_good` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Memory supply stable |
| skip_dummy | input | 1 | 1: finish wake-up with a quiet interval; 0: with two dummy reads |
| sleep_req | input | 1 | Request deep power-down |
| wake_req | input | 1 | Request exit from deep power-down |
| host_sel | input | 1 | Host wants the memory selected (used while ready) |
| rd_done | input | 1 | Cycle generator finished one dummy read |
| lost_ack | input | 1 | Software acknowledges the data-lost flag |
| cs_n | output | 1 | Active-low chip select pin |
| zz_n | output | 1 | Active-low deep power-down pin |
| ready | output | 1 | Memory available for normal access |
| rd_req | output | 1 | Dummy read request to the cycle generator |
| data_lost | output | 1 | Contents lost by deep power-down, sticky |

## Verification
The hardest situations to reach are the held requests. One is a wake that lands inside the minimum sleep dwell. The other is a sleep that lands during a settle interval and must fire the cycle after `ready` appears. The stimulus pulses each request at a chosen point inside the relevant wait. It then counts the cycles `zz_n` stays low, or watches the cycle right after `ready`. A dropped wake followed by a sleep, and a power loss in mid-sequence, are also steered on purpose. A behavioural model follows every one of these runs cycle by cycle.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    typedef enum logic [2:0] {
        PS_OFF,
        PS_INIT_WAIT,
        PS_DUMMY,
        PS_QUIET,
        PS_READY,
        PS_ZZ_MIN,
        PS_DEEP,
        PS_WAKE_WAIT
    } pwr_state_e;

    typedef struct packed {
        logic cs_n;
        logic zz_n;
        logic ready;
        logic rd_req;
    } pin_drive_t;

    function automatic logic is_asleep(pwr_state_e s);
        return (s == PS_ZZ_MIN) || (s == PS_DEEP);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Counter preload on entry to a state: the state then lasts load+1 cycles.
    function automatic int unsigned interval_for(pwr_state_e s, int unsigned t_init,
                                                 int unsigned t_quiet, int unsigned t_zz);
        case (s)
            PS_INIT_WAIT, PS_WAKE_WAIT: return t_init - 1;
            PS_QUIET:                   return t_quiet - 1;
            PS_ZZ_MIN:                  return t_zz - 1;
            default:                    return 0;
        endcase
    endfunction

    function automatic pin_drive_t drive_for(pwr_state_e s, logic host_sel);
        pin_drive_t d;
        d = '{cs_n: 1'b1, zz_n: 1'b1, ready: 1'b0, rd_req: 1'b0};
        case (s)
            PS_DUMMY: begin
                d.cs_n   = 1'b0;
                d.rd_req = 1'b1;
            end
            PS_READY: begin
                d.cs_n  = ~host_sel;
                d.ready = 1'b1;
            end
            PS_ZZ_MIN, PS_DEEP: d.zz_n = 1'b0;
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/psram_interval_timer.sv
module psram_interval_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

    // R2: an idle counter never wraps, a running one steps by one
    assert_timer_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && expired) |=> expired);
    assert_timer_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && !expired) |=> ((cnt + W'(1)) == $past(cnt)));
endmodule

// File: rtl/psram_req_hold.sv
module psram_req_hold (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic in_sleep,
    input  logic clr_sleep,
    input  logic clr_wake,
    output logic sleep_eff,
    output logic wake_eff
);
    logic sleep_pend;
    logic wake_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_pend <= 1'b0;
            wake_pend  <= 1'b0;
        end else begin
            if (clr_sleep)
                sleep_pend <= 1'b0;
            else if (sleep_req && !in_sleep)
                sleep_pend <= 1'b1;
            if (clr_wake)
                wake_pend <= 1'b0;
            else if (wake_req && in_sleep)
                wake_pend <= 1'b1;
        end
    end

    assign sleep_eff = sleep_pend | sleep_req;
    assign wake_eff  = wake_pend | wake_req;

    // R9: an accepted sleep request is remembered until consumed
    assert_sleep_held_R9: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && !in_sleep && !clr_sleep) |=> sleep_pend);
    // R10: a wake request while awake leaves nothing behind
    assert_wake_dropped_R10: assert property (@(posedge clk) disable iff (rst)
        (!in_sleep && !wake_pend) |=> !wake_pend);
endmodule

// File: rtl/psram_dummy_reads.sv
module psram_dummy_reads #(
    parameter int unsigned N_READS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic rd_done,
    output logic last
);
    localparam int unsigned CW = $clog2(N_READS + 1);

    logic [CW-1:0] cnt;

    assign last = active && rd_done && (cnt == CW'(N_READS - 1));

    always_ff @(posedge clk) begin
        if (rst || !active || last)
            cnt <= '0;
        else if (rd_done)
            cnt <= cnt + CW'(1);
    end

    // R3: completions counted never reach the target without ending the phase
    assert_dummy_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(N_READS));
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
    import psram_pwr_pkg::*;
#(
    parameter int unsigned T_INIT  = 40000,
    parameter int unsigned T_QUIET = 60000,
    parameter int unsigned T_ZZMIN = 200,
    parameter int unsigned N_READS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    input  logic skip_dummy,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic host_sel,
    input  logic rd_done,
    input  logic lost_ack,
    output logic cs_n,
    output logic zz_n,
    output logic ready,
    output logic rd_req,
    output logic data_lost
);
    localparam int unsigned TMAX = max3(T_INIT, T_QUIET, T_ZZMIN);
    localparam int unsigned TW   = $clog2(TMAX + 1);

    pwr_state_e   state_q, state_d;
    logic         tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic         sleep_eff, wake_eff, clr_sleep, clr_wake;
    logic         dummy_last, lost_set;
    pin_drive_t   pins;

    psram_interval_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    psram_req_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .sleep_req(sleep_req),
        .wake_req (wake_req),
        .in_sleep (is_asleep(state_q)),
        .clr_sleep(clr_sleep),
        .clr_wake (clr_wake),
        .sleep_eff(sleep_eff),
        .wake_eff (wake_eff)
    );

    psram_dummy_reads #(.N_READS(N_READS)) u_dummy (
        .clk    (clk),
        .rst    (rst),
        .active (state_q == PS_DUMMY),
        .rd_done(rd_done),
        .last   (dummy_last)
    );

    always_comb begin
        state_d = state_q;
        if (!pwr_good) begin
            state_d = PS_OFF;
        end else begin
            case (state_q)
                PS_OFF: state_d = PS_INIT_WAIT;
                PS_INIT_WAIT, PS_WAKE_WAIT:
                    if (tmr_expired) state_d = skip_dummy ? PS_QUIET : PS_DUMMY;
                PS_DUMMY:  if (dummy_last) state_d = PS_READY;
                PS_QUIET:  if (tmr_expired) state_d = PS_READY;
                PS_READY:  if (sleep_eff) state_d = PS_ZZ_MIN;
                PS_ZZ_MIN: if (tmr_expired) state_d = wake_eff ? PS_WAKE_WAIT : PS_DEEP;
                PS_DEEP:   if (wake_eff) state_d = PS_WAKE_WAIT;
                default:   state_d = PS_OFF;
            endcase
        end
    end

    assign tmr_load  = (state_d != state_q);
    assign tmr_val   = TW'(interval_for(state_d, T_INIT, T_QUIET, T_ZZMIN));
    assign lost_set  = is_asleep(state_q) && (state_d == PS_WAKE_WAIT);
    assign clr_sleep = (state_d == PS_ZZ_MIN) || (state_d == PS_OFF);
    assign clr_wake  = lost_set || (state_d == PS_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PS_OFF;
            data_lost <= 1'b0;
        end else begin
            state_q <= state_d;
            if (lost_set)
                data_lost <= 1'b1;
            else if (lost_ack)
                data_lost <= 1'b0;
        end
    end

    assign pins   = drive_for(state_q, host_sel);
    assign cs_n   = pins.cs_n;
    assign zz_n   = pins.zz_n;
    assign ready  = pins.ready;
    assign rd_req = pins.rd_req;

    // Run-length of the sleep pin, kept for the dwell check below
    logic [TW-1:0] zz_run;
    always_ff @(posedge clk) begin
        if (rst || zz_n)
            zz_run <= '0;
        else if (zz_run != '1)
            zz_run <= zz_run + TW'(1);
    end

    assert_zz_min_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(zz_n) && state_q == PS_WAKE_WAIT) |-> (zz_run >= TW'(T_ZZMIN)));
    assert_sleep_cs_high_R6: assert property (@(posedge clk) disable iff (rst)
        !zz_n |-> cs_n);
    assert_ready_pins_R5: assert property (@(posedge clk) disable iff (rst)
        ready |-> (zz_n && !rd_req));
    assert_rdreq_cs_R3: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> !cs_n);
    assert_lost_on_exit_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(data_lost) |-> (zz_n && $past(!zz_n)));
    assert_lost_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (data_lost && !lost_ack) |=> data_lost);
    assert_power_loss_R11: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (!ready && cs_n && zz_n && !rd_req));
endmodule

// File: tb/psram_pwr_seq_bench.sv
`timescale 1ns/100ps
module psram_pwr_seq_bench;
    localparam int TI = 20;
    localparam int TQ = 30;
    localparam int TZ = 6;

    localparam int M_OFF = 0, M_INIT = 1, M_DUMMY = 2, M_QUIET = 3,
                   M_READY = 4, M_ZZ = 5, M_DEEP = 6, M_WAKE = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_good = 1'b0, skip_dummy = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
    logic host_sel = 1'b0, rd_done = 1'b0, lost_ack = 1'b0;
    logic cs_n, zz_n, ready, rd_req, data_lost;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    psram_pwr_seq #(.T_INIT(TI), .T_QUIET(TQ), .T_ZZMIN(TZ), .N_READS(2)) u_psram_pwr_seq (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .skip_dummy(skip_dummy),
        .sleep_req(sleep_req), .wake_req(wake_req), .host_sel(host_sel),
        .rd_done(rd_done), .lost_ack(lost_ack), .cs_n(cs_n), .zz_n(zz_n),
        .ready(ready), .rd_req(rd_req), .data_lost(data_lost)
    );

    // Cycle generator stand-in: one completion every second requested cycle
    int seen = 0;
    always @(negedge clk) begin
        if (rst || !rd_req) begin
            rd_done <= 1'b0;
            seen = 0;
        end else if (!rd_done && seen >= 1) begin
            rd_done <= 1'b1;
            seen = 0;
        end else begin
            rd_done <= 1'b0;
            seen = seen + 1;
        end
    end

    // Behavioural reference model
    int m = M_OFF, rem = 0, nd = 0;
    bit ps = 0, pw = 0, lost = 0;
    always @(posedge clk) begin
        int nxt;
        bit asleep;
        if (rst) begin
            m = M_OFF; rem = 0; nd = 0; ps = 0; pw = 0; lost = 0;
        end else begin
            nxt = m;
            asleep = (m == M_ZZ) || (m == M_DEEP);
            if (!pwr_good) nxt = M_OFF;
            else case (m)
                M_OFF:          nxt = M_INIT;
                M_INIT, M_WAKE: if (rem == 1) nxt = skip_dummy ? M_QUIET : M_DUMMY;
                M_DUMMY:        if (rd_done && nd == 1) nxt = M_READY;
                M_QUIET:        if (rem == 1) nxt = M_READY;
                M_READY:        if (ps || sleep_req) nxt = M_ZZ;
                M_ZZ:           if (rem == 1) nxt = (pw || wake_req) ? M_WAKE : M_DEEP;
                M_DEEP:         if (pw || wake_req) nxt = M_WAKE;
                default:        nxt = M_OFF;
            endcase
            if (nxt == M_ZZ || nxt == M_OFF) ps = 0;
            else if (sleep_req && !asleep) ps = 1;
            if ((asleep && nxt == M_WAKE) || nxt == M_OFF) pw = 0;
            else if (wake_req && asleep) pw = 1;
            if (asleep && nxt == M_WAKE) lost = 1;
            else if (lost_ack) lost = 0;
            if (m == M_DUMMY && rd_done) nd = (nd == 1) ? 0 : nd + 1;
            else if (m != M_DUMMY) nd = 0;
            if (nxt != m) begin
                case (nxt)
                    M_INIT, M_WAKE: rem = TI;
                    M_QUIET:        rem = TQ;
                    M_ZZ:           rem = TZ;
                    default:        rem = 0;
                endcase
            end else if (rem > 0) rem = rem - 1;
            m = nxt;
        end
    end

    function automatic string tag_of(int md);
        case (md)
            M_OFF:   return "R1";
            M_INIT:  return "R2";
            M_DUMMY: return "R3";
            M_QUIET: return "R4";
            M_READY: return "R5";
            M_ZZ:    return "R6";
            M_DEEP:  return "R10";
            default: return "R7";
        endcase
    endfunction

    // Per-cycle comparison, half a clock away from the active edge
    always @(negedge clk) begin
        logic [4:0] exp_v, act_v;
        #0.5;
        if (!done) begin
            exp_v = {1'b1, 1'b1, 1'b0, 1'b0, lost};
            case (m)
                M_DUMMY: begin exp_v[4] = 1'b0; exp_v[1] = 1'b1; end
                M_READY: begin exp_v[4] = ~host_sel; exp_v[2] = 1'b1; end
                M_ZZ, M_DEEP: exp_v[3] = 1'b0;
                default: ;
            endcase
            act_v = {cs_n, zz_n, ready, rd_req, data_lost};
            checks++;
            if (act_v !== exp_v) begin
                fails++;
                $display("FAIL %s model cycle %0d: {cs_n,zz_n,ready,rd_req,lost} actual %b expected %b",
                         (act_v[0] !== exp_v[0]) ? "R8" : tag_of(m), cyc, act_v, exp_v);
            end
        end
    end

    task automatic chk(input string req, input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, actual, expected);
        end
    endtask

    task automatic chk_int(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1; tick(1); wake_req = 1'b0;
    endtask

    task automatic wait_ready(input int lim, output int n, output int reads, output bit saw_rd);
        n = 0; reads = 0; saw_rd = 0;
        while (!ready && n < lim) begin
            tick(1);
            n++;
            if (rd_req) saw_rd = 1;
            if (rd_done) reads++;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, reads, z;
        bit saw;
        tick(3);
        // R1: reset outputs
        chk("R1 cs_n", cs_n, 1'b1);
        chk("R1 zz_n", zz_n, 1'b1);
        chk("R1 ready", ready, 1'b0);
        chk("R1 rd_req", rd_req, 1'b0);
        chk("R1 data_lost", data_lost, 1'b0);
        rst = 1'b0;
        tick(2);
        chk("R11 off while power low", ready, 1'b0);

        // R2 then R3: power-up with dummy reads
        pwr_good = 1'b1;
        tick(1);
        chk("R2 cs_n in settle", cs_n, 1'b1);
        wait_ready(200, n, reads, saw);
        chk("R2 settle long enough", n > TI, 1'b1);
        chk("R3 dummy reads requested", saw, 1'b1);
        chk_int("R3 dummy completions", reads, 2);
        chk("R3 ready reached", ready, 1'b1);

        // R5: host select passes through
        host_sel = 1'b1; #0.2;
        chk("R5 cs_n follows host_sel=1", cs_n, 1'b0);
        host_sel = 1'b0; #0.2;
        chk("R5 cs_n follows host_sel=0", cs_n, 1'b1);

        // R10: stray wake is dropped, sleep then stays down
        pulse_wake();
        tick(2);
        pulse_sleep();
        chk("R6 zz_n low after sleep", zz_n, 1'b0);
        chk("R6 ready low in sleep", ready, 1'b0);
        tick(TZ + 10);
        chk("R10 stays in power-down", zz_n, 1'b0);
        chk("R8 no loss before exit", data_lost, 1'b0);
        pulse_sleep();
        tick(2);
        chk("R10 sleep in power-down ignored", zz_n, 1'b0);

        // R7 with R4: wake via quiet interval
        skip_dummy = 1'b1;
        pulse_wake();
        chk("R7 zz_n high on wake", zz_n, 1'b1);
        chk("R7 cs_n high on wake", cs_n, 1'b1);
        chk("R8 data_lost set on exit", data_lost, 1'b1);
        wait_ready(200, n, reads, saw);
        chk_int("R4 settle plus quiet cycles", n, TI + TQ);
        chk("R4 no dummy read", saw, 1'b0);
        tick(3);
        chk("R8 data_lost sticky", data_lost, 1'b1);
        lost_ack = 1'b1; tick(1); lost_ack = 1'b0;
        chk("R8 data_lost cleared", data_lost, 1'b0);

        // R6 and R9: wake held during minimum dwell
        skip_dummy = 1'b0;
        pulse_sleep();
        chk("R6 zz_n low", zz_n, 1'b0);
        z = 1;
        pulse_wake();
        while (!zz_n && z < 100) begin
            z++;
            tick(1);
        end
        chk_int("R9 held wake ends dwell at minimum", z, TZ);
        chk("R8 data_lost set again", data_lost, 1'b1);
        wait_ready(200, n, reads, saw);
        chk("R7 dummy reads after wake", saw, 1'b1);
        chk("R7 ready after wake", ready, 1'b1);
        lost_ack = 1'b1; tick(1); lost_ack = 1'b0;

        // R11: power loss, then R9 sleep held through power-up
        pwr_good = 1'b0;
        tick(1);
        chk("R11 ready dropped", ready, 1'b0);
        chk("R11 cs_n high", cs_n, 1'b1);
        chk("R11 zz_n high", zz_n, 1'b1);
        pwr_good = 1'b1;
        tick(1);
        tick(3);
        pulse_sleep();
        wait_ready(200, n, reads, saw);
        chk("R9 ready reached with held sleep", ready, 1'b1);
        tick(1);
        chk("R9 held sleep applied", zz_n, 1'b0);

        // R11: power loss during power-down
        pwr_good = 1'b0;
        tick(1);
        chk("R11 zz_n released", zz_n, 1'b1);
        chk("R11 rd_req low", rd_req, 1'b0);
        tick(2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule